// File: doc/BRIEF.md
# Posted-Pending Interrupt Controller

This block gathers interrupt events from a set of hardware sources (timers, GPIO and similar) and turns them into one request line and one vector byte for a CPU. Every source owns a posting flop that remembers an event until software clears it or the CPU accepts the interrupt. A posted event only counts once its mask bit is set. When the mask bit is clear, the post is held but no request is raised. A fixed-priority encoder chooses among the pending sources and presents an 8-bit vector, which is the low byte of the handler address in the interrupt table.

The request output is gated by a global enable input. Because posts survive masking, an interrupt becomes active in three ways: a new event arrives on an unmasked source, a mask write unmasks a source that was already posted, or the global enable rises while a source is pending. A small register port lets software write the mask, read it back, read the posted bits, and clear posted bits by writing ones. A taken strobe from the CPU clears the post of the source whose vector is on the output in that same cycle.

Top module: `irq_post_ctrl`

## Requirements
- R1: After reset all posted bits and all mask bits are 0, `irq_o` is 0, and both register reads return 0.
- R2: An event on `src_evt_i[i]` sets posted bit i at the next clock edge. The bit stays set while the source is masked. The posted bits are read with `reg_sel_i`=1 on `reg_rdata_o`, bit i being source i.
- R3: A register write with `reg_sel_i`=1 clears each posted bit whose `reg_wdata_i` bit is 1. A bit written as 0 leaves its posted bit unchanged.
- R4: When an event and a clear hit the same source in the same cycle, the posted bit ends up set.
- R5: Source i is pending when posted bit i and mask bit i are both 1. `irq_o` is 1 in a cycle exactly when some source is pending and `gie_i` is 1 in that cycle.
- R6: A mask write that unmasks an already posted source raises `irq_o` in the cycle after the write, provided `gie_i` is 1.
- R7: When `gie_i` goes from 0 to 1 while a source is pending, `irq_o` rises in the same cycle.
- R8: Among the pending sources, the lowest index wins. `vector_o` is 4 times the winning index, so source 7 (GPIO) gives 0x1C. `vector_o` is 0 when nothing is pending.
- R9: `taken_i`, sampled together with `vector_o`, clears the posted bit of the winning source at the next edge and leaves every other posted bit unchanged.
- R10: A register write with `reg_sel_i`=0 loads the mask from `reg_wdata_i`. A read with `reg_sel_i`=0 returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_evt_i | input | NUM_SRC | Per-source event strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = mask, 1 = posted/clear |
| reg_wdata_i | input | NUM_SRC | Register write data |
| reg_rdata_o | output | NUM_SRC | Read data for the selected register (combinational) |
| gie_i | input | 1 | Global interrupt enable |
| taken_i | input | 1 | CPU accepts the interrupt whose vector is presented |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | VEC_W | Vector low-address byte of the winning source |

## Verification
Events, clears, mask writes and taken strobes change state at the next rising edge, so their effect first shows one cycle after the stimulus. `irq_o`, `vector_o` and `reg_rdata_o` are combinational from that state and from the present `gie_i` and `reg_sel_i`, so a rise of the global enable shows within the same cycle. The bench drives inputs just after the falling edge and compares all three outputs a moment later against a behavioural model. It then advances the model with the inputs that the next rising edge will sample, so each output is checked in the cycle it is due.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;

   // register select encoding on the register port
   typedef enum logic {
      REG_MASK = 1'b0,
      REG_POST = 1'b1
   } irq_reg_sel_e;

   // vector byte for a given source index
   function automatic int unsigned vec_of(input int unsigned idx, input int unsigned stride);
      return idx * stride;
   endfunction

endpackage

// File: rtl/irq_post_latch.sv
module irq_post_latch #(
   parameter int unsigned N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);

   initial begin
      if (N < 1) $error("irq_post_latch: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic post_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)          post_q <= 1'b0;
         else if (set_i[g])    post_q <= 1'b1;   // set dominates clear
         else if (clr_i[g])    post_q <= 1'b0;
      end
      assign q_o[g] = post_q;
   end

   // R4
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R3
   clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N         = 8,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     pend_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   assign any_o = |pend_i;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         idx_o = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
         end
      end
   end else begin : g_high_first
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N; i++) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
         end
      end
   end

   // R8
   winner_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_o |-> pend_i[idx_o]);

endmodule

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl
   import irq_post_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 8,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_STRIDE = 4,
   parameter bit          LOW_FIRST  = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_evt_i,
   input  logic               reg_we_i,
   input  logic               reg_sel_i,
   input  logic [NUM_SRC-1:0] reg_wdata_i,
   output logic [NUM_SRC-1:0] reg_rdata_o,
   input  logic               gie_i,
   input  logic               taken_i,
   output logic               irq_o,
   output logic [VEC_W-1:0]   vector_o
);

   localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned VEC_TOP = (NUM_SRC - 1) * VEC_STRIDE;

   initial begin
      if (NUM_SRC < 2)            $error("irq_post_ctrl: need at least two sources");
      if (VEC_STRIDE < 1)         $error("irq_post_ctrl: vector stride must be nonzero");
      if (VEC_TOP >= (1 << VEC_W)) $error("irq_post_ctrl: vectors do not fit in VEC_W bits");
   end

   irq_reg_sel_e              sel;
   logic [NUM_SRC-1:0]        mask_q;
   logic [NUM_SRC-1:0]        posted;
   logic [NUM_SRC-1:0]        pending;
   logic [NUM_SRC-1:0]        sw_clr;
   logic [NUM_SRC-1:0]        ack_clr;
   logic                      pend_any;
   logic [IDX_W-1:0]          win_idx;

   assign sel = irq_reg_sel_e'(reg_sel_i);

   // mask register
   always_ff @(posedge clk_i) begin
      if (!rst_ni)                          mask_q <= '0;
      else if (reg_we_i && sel == REG_MASK) mask_q <= reg_wdata_i;
   end

   // write-one-to-clear and acknowledge clear
   assign sw_clr = (reg_we_i && sel == REG_POST) ? reg_wdata_i : '0;

   always_comb begin
      ack_clr = '0;
      if (taken_i && pend_any) ack_clr[win_idx] = 1'b1;
   end

   irq_post_latch #(.N(NUM_SRC)) i_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (src_evt_i),
      .clr_i  (sw_clr | ack_clr),
      .q_o    (posted)
   );

   assign pending = posted & mask_q;

   irq_prio_enc #(.N(NUM_SRC), .LOW_FIRST(LOW_FIRST)) i_enc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pending),
      .any_o  (pend_any),
      .idx_o  (win_idx)
   );

   assign irq_o       = pend_any & gie_i;
   assign vector_o    = pend_any ? VEC_W'(vec_of(int'(win_idx), VEC_STRIDE)) : '0;
   assign reg_rdata_o = (sel == REG_POST) ? posted : mask_q;

   // R9
   taken_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken_i && pend_any && !src_evt_i[win_idx]) |=> !posted[$past(win_idx)]);

   // R5
   irq_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (gie_i && (posted & mask_q) != '0));

   // R8
   vector_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ((int'(vector_o) % VEC_STRIDE) == 0 && int'(vector_o) <= VEC_TOP));

endmodule

// File: tb/test_irq_post_ctrl.sv
`timescale 1ns/1ps
module test_irq_post_ctrl;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic         we = 1'b0;
   logic         sel = 1'b0;
   logic [N-1:0] wd = '0;
   logic [N-1:0] rdata;
   logic         gie = 1'b0;
   logic         taken = 1'b0;
   logic         irq;
   logic [7:0]   vec;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // model state
   logic [N-1:0] m_post = '0;
   logic [N-1:0] m_mask = '0;

   always #5 clk = ~clk;

   irq_post_ctrl i_irq_post_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .src_evt_i(evt), .reg_we_i(we), .reg_sel_i(sel),
      .reg_wdata_i(wd), .reg_rdata_o(rdata), .gie_i(gie), .taken_i(taken),
      .irq_o(irq), .vector_o(vec)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one cycle: drive, compare, advance model
   task automatic step(input string req, input logic [N-1:0] e, input logic w, input logic s,
                       input logic [N-1:0] d, input logic g, input logic t);
      logic [N-1:0] pend;
      logic [N-1:0] clr;
      int           win;
      @(negedge clk);
      evt = e; we = w; sel = s; wd = d; gie = g; taken = t;
      #1;
      pend = m_post & m_mask;
      win = -1;
      for (int i = N - 1; i >= 0; i--) if (pend[i]) win = i;
      chk(req, int'(irq), int'(win >= 0 && g));
      chk(req, int'(vec), (win >= 0) ? win * 4 : 0);
      chk(req, int'(rdata), int'(s ? m_post : m_mask));
      clr = (w && s) ? d : '0;
      if (t && win >= 0) clr[win] = 1'b1;
      if (w && !s) m_mask = d;
      m_post = e | (m_post & ~clr);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      // R1: reset state visible during reset
      repeat (3) @(negedge clk);
      sel = 1'b1; #1; chk("R1", int'(rdata), 0); chk("R1", int'(irq), 0);
      sel = 1'b0; #1; chk("R1", int'(rdata), 0);
      @(negedge clk); rst_n = 1'b1;
      step("R1", '0, 0, 1, '0, 1, 0);
      step("R1", '0, 0, 0, '0, 1, 0);
      // R2: post while masked, persists
      step("R2", 8'h08, 0, 1, '0, 1, 0);
      step("R2", '0, 0, 1, '0, 1, 0);
      step("R2", '0, 0, 1, '0, 1, 0);
      // R6: unmask old post, irq next cycle; R10 mask readback
      step("R6", '0, 1, 0, 8'h08, 1, 0);
      step("R6", '0, 0, 0, '0, 1, 0);
      step("R10", '0, 0, 0, '0, 1, 0);
      // R7: gie low then rises while pending
      step("R7", '0, 0, 1, '0, 0, 0);
      step("R7", '0, 0, 1, '0, 1, 0);
      // R8: source 7 and 3 pending, lowest wins, then GPIO vector 0x1C
      step("R8", 8'h80, 1, 0, 8'hFF, 1, 0);
      step("R8", '0, 0, 1, '0, 1, 0);
      step("R3", '0, 1, 1, 8'h08, 1, 0);
      step("R8", '0, 0, 1, '0, 1, 0);
      // R3: writing zeros has no effect
      step("R3", '0, 1, 1, 8'h00, 1, 0);
      step("R3", '0, 0, 1, '0, 1, 0);
      // R4: event and clear same cycle
      step("R4", 8'h02, 1, 1, 8'h82, 1, 0);
      step("R4", '0, 0, 1, '0, 1, 0);
      // R9: taken clears winner only
      step("R9", 8'h20, 0, 1, '0, 1, 0);
      step("R9", '0, 0, 1, '0, 1, 1);
      step("R9", '0, 0, 1, '0, 1, 0);
      step("R9", '0, 0, 1, '0, 1, 1);
      step("R9", '0, 0, 1, '0, 1, 0);
      // R5: mixed stimulus from an LFSR
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step("R5", (lfsr[3:0] == 0) ? lfsr[15:8] : '0, lfsr[4] & lfsr[5], lfsr[6],
              lfsr[15:8] ^ lfsr[7:0], lfsr[7] | lfsr[9], lfsr[11] & lfsr[2]);
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule